// File: doc/BRIEF.md
# System Control Register Bank

This block is the register file behind a processor core's system-control coprocessor. The core reaches it with move-to and move-from coprocessor operations, which arrive here as a register index, a valid strobe, a write flag and a 32-bit write word. The block answers reads on a combinational read-data bus in the same cycle. It holds three registers. The global control word carries the instruction-SRAM enable, data-SRAM enable, write-buffer enable and endianness bits. A write to the core-control register starts a low-power wait. The trace process-identifier register is mirrored onto output pins.

The SRAM enables come out of reset from a strap input, so a warm reset can keep SRAM that software has already loaded. A write to the core-control register holds the core clock enable low until an interrupt or debug request is seen. Each write to the process-identifier register drives a one-cycle strobe next to the mirrored value, so trace logic can record the change.

Top module: `scp_regbank`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `big_endian`, `wbuf_en`, `pid_out` and `pid_wr_pulse`, and sets `core_clk_en` to 1.
- R2: `isram_en` and `dsram_en` take the value of `strap_sram_en` at each reset edge, so both are 1 after a reset with the strap high and 0 with the strap low.
- R3: A write to index 1 updates four fields at the next clock edge: data-SRAM enable (bit 2), write-buffer enable (bit 3), endianness (bit 7) and instruction-SRAM enable (bit 12). A read of index 1 returns those fields at the same bit positions, with every other bit reading 0.
- R4: `big_endian` equals control bit 7 (1 = big-endian, 0 = little-endian). It changes only on a write to index 1.
- R5: A write to index 7 drives `core_clk_en` low from the following cycle. It stays low until `wake_req` is sampled high at a clock edge, and it is high again in the cycle after that edge.
- R6: If `wake_req` is already high when the index-7 write is sampled, `core_clk_en` is low for exactly one cycle.
- R7: A write to index 13 places the write word on `pid_out` from the next cycle. A read of index 13 returns it. `pid_out` changes on no other access.
- R8: `pid_wr_pulse` is high for exactly the one cycle after each index-13 write, and never after any other access.
- R9: Reads of any index other than 1 and 13 (index 7 included) return 0. Reads with `acc_valid` low return 0. Writes to other indices, and writes with `acc_valid` low, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_sram_en | input | 1 | Reset value of both SRAM enables |
| wake_req | input | 1 | Interrupt or debug request that ends the wait |
| acc_valid | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_idx | input | 4 | Register index |
| acc_wdata | input | 32 | Write word |
| acc_rdata | output | 32 | Read word (combinational) |
| isram_en | output | 1 | Instruction SRAM enable |
| dsram_en | output | 1 | Data SRAM enable |
| wbuf_en | output | 1 | Write buffer enable |
| big_endian | output | 1 | Endianness select |
| core_clk_en | output | 1 | Core clock enable |
| pid_out | output | 32 | Mirrored process identifier |
| pid_wr_pulse | output | 1 | One-cycle strobe after a process-ID write |

## Verification
The control word is written with all ones, all zeros, single-field words and the complement of the field mask. This separates a correct field mask from a stuck, missing or shifted bit, and confirms that reserved bits read 0. The wait operation is tried twice: once with the wake request arriving several cycles later, and once with the request already pending, which separates the normal release from the one-cycle case. Writes to unimplemented indices and writes with the valid strobe low are followed by reads of both registers and a look at the process-ID strobe. Two resets with opposite strap values tell a strap-loaded enable apart from a constant.

// File: rtl/scp_pkg.sv
package scp_pkg;

    localparam int DATA_W = 32;
    localparam int IDX_W  = 4;

    localparam logic [IDX_W-1:0] CTRL_IDX = 4'd1;
    localparam logic [IDX_W-1:0] CORE_IDX = 4'd7;
    localparam logic [IDX_W-1:0] PID_IDX  = 4'd13;

    localparam int BIT_DSRAM  = 2;
    localparam int BIT_WBUF   = 3;
    localparam int BIT_ENDIAN = 7;
    localparam int BIT_ISRAM  = 12;

    typedef struct packed {
        logic isram_en;
        logic big_endian;
        logic wbuf_en;
        logic dsram_en;
    } ctrl_t;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_CTRL,
        ACC_CORE,
        ACC_PID,
        ACC_OTHER
    } acc_kind_e;

    function automatic acc_kind_e decode_access(logic valid, logic [IDX_W-1:0] idx);
        if (!valid)               return ACC_NONE;
        else if (idx == CTRL_IDX) return ACC_CTRL;
        else if (idx == CORE_IDX) return ACC_CORE;
        else if (idx == PID_IDX)  return ACC_PID;
        else                      return ACC_OTHER;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(ctrl_t c);
        logic [DATA_W-1:0] w;
        w             = '0;
        w[BIT_DSRAM]  = c.dsram_en;
        w[BIT_WBUF]   = c.wbuf_en;
        w[BIT_ENDIAN] = c.big_endian;
        w[BIT_ISRAM]  = c.isram_en;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] read_mux(acc_kind_e kind, ctrl_t c,
                                                   logic [DATA_W-1:0] pid);
        case (kind)
            ACC_CTRL: return ctrl_to_word(c);
            ACC_PID:  return pid;
            default:  return '0;
        endcase
    endfunction

endpackage

// File: rtl/scp_ctrl_reg.sv
module scp_ctrl_reg
    import scp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  strap_sram_en,
    input  logic  wr_en,
    input  ctrl_t wr_val,
    output ctrl_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q.isram_en   <= strap_sram_en;
            q.dsram_en   <= strap_sram_en;
            q.wbuf_en    <= 1'b0;
            q.big_endian <= 1'b0;
        end else if (wr_en) begin
            q <= wr_val;
        end
    end
endmodule

// File: rtl/scp_wfi.sv
module scp_wfi (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic wake,
    output logic clk_en
);
    logic sleeping;

    always_ff @(posedge clk) begin
        if (rst)          sleeping <= 1'b0;
        else if (start)   sleeping <= 1'b1;
        else if (wake)    sleeping <= 1'b0;
    end

    assign clk_en = ~sleeping;
endmodule

// File: rtl/scp_pid_reg.sv
module scp_pid_reg
    import scp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] pid,
    output logic              pulse
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pid   <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= wr_en;
            if (wr_en) pid <= wdata;
        end
    end
endmodule

// File: rtl/scp_regbank.sv
module scp_regbank
    import scp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_sram_en,
    input  logic              wake_req,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [IDX_W-1:0]  acc_idx,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              isram_en,
    output logic              dsram_en,
    output logic              wbuf_en,
    output logic              big_endian,
    output logic              core_clk_en,
    output logic [DATA_W-1:0] pid_out,
    output logic              pid_wr_pulse
);
    acc_kind_e kind;
    ctrl_t     ctrl_q;
    ctrl_t     ctrl_wr;
    logic      wr_ctrl, wr_core, wr_pid;

    assign kind    = decode_access(acc_valid, acc_idx);
    assign wr_ctrl = acc_write && (kind == ACC_CTRL);
    assign wr_core = acc_write && (kind == ACC_CORE);
    assign wr_pid  = acc_write && (kind == ACC_PID);

    assign ctrl_wr.isram_en   = acc_wdata[BIT_ISRAM];
    assign ctrl_wr.dsram_en   = acc_wdata[BIT_DSRAM];
    assign ctrl_wr.wbuf_en    = acc_wdata[BIT_WBUF];
    assign ctrl_wr.big_endian = acc_wdata[BIT_ENDIAN];

    scp_ctrl_reg u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .strap_sram_en (strap_sram_en),
        .wr_en         (wr_ctrl),
        .wr_val        (ctrl_wr),
        .q             (ctrl_q)
    );

    scp_wfi u_wfi (
        .clk    (clk),
        .rst    (rst),
        .start  (wr_core),
        .wake   (wake_req),
        .clk_en (core_clk_en)
    );

    scp_pid_reg u_pid (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_pid),
        .wdata (acc_wdata),
        .pid   (pid_out),
        .pulse (pid_wr_pulse)
    );

    assign acc_rdata  = acc_write ? '0 : read_mux(kind, ctrl_q, pid_out);
    assign isram_en   = ctrl_q.isram_en;
    assign dsram_en   = ctrl_q.dsram_en;
    assign wbuf_en    = ctrl_q.wbuf_en;
    assign big_endian = ctrl_q.big_endian;
endmodule

// File: rtl/scp_regbank_chk.sv
module scp_regbank_chk
    import scp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              strap_sram_en,
    input logic              wake_req,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [IDX_W-1:0]  acc_idx,
    input logic [DATA_W-1:0] acc_rdata,
    input logic              isram_en,
    input logic              big_endian,
    input logic              core_clk_en,
    input logic [DATA_W-1:0] pid_out,
    input logic              pid_wr_pulse
);
    logic w_ctrl, w_core, w_pid, rd_other;
    assign w_ctrl   = acc_valid && acc_write && (acc_idx == CTRL_IDX);
    assign w_core   = acc_valid && acc_write && (acc_idx == CORE_IDX);
    assign w_pid    = acc_valid && acc_write && (acc_idx == PID_IDX);
    assign rd_other = acc_valid && !acc_write &&
                      (acc_idx != CTRL_IDX) && (acc_idx != PID_IDX);

    a_r1_reset_little_endian: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!big_endian && core_clk_en && !pid_wr_pulse));

    a_r2_strap_loads_isram: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (isram_en == $past(strap_sram_en)));

    a_r4_endian_holds: assert property (@(posedge clk) disable iff (rst)
        !w_ctrl |=> $stable(big_endian));

    a_r5_wait_drops_enable: assert property (@(posedge clk) disable iff (rst)
        w_core |=> !core_clk_en);

    a_r5_wake_releases: assert property (@(posedge clk) disable iff (rst)
        (!core_clk_en && wake_req && !w_core) |=> core_clk_en);

    a_r7_pid_holds: assert property (@(posedge clk) disable iff (rst)
        !w_pid |=> $stable(pid_out));

    a_r8_pulse_follows_write: assert property (@(posedge clk) disable iff (rst)
        w_pid |=> pid_wr_pulse);

    a_r8_pulse_needs_write: assert property (@(posedge clk) disable iff (rst)
        !w_pid |=> !pid_wr_pulse);

    a_r9_other_reads_zero: assert property (@(posedge clk) disable iff (rst)
        rd_other |-> (acc_rdata == '0));
endmodule

bind scp_regbank scp_regbank_chk u_chk (.*);

// File: tb/tb_scp_regbank.sv
`timescale 1ns/1ps
module tb_scp_regbank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap_sram_en = 1'b1;
    logic        wake_req = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [3:0]  acc_idx = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        isram_en, dsram_en, wbuf_en, big_endian, core_clk_en, pid_wr_pulse;
    logic [31:0] pid_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    scp_regbank dut (.*);

    // {write word, expected readback of index 1}
    localparam logic [63:0] VEC [6] = '{
        {32'hFFFF_FFFF, 32'h0000_108C},
        {32'h0000_0000, 32'h0000_0000},
        {32'h0000_0080, 32'h0000_0080},
        {32'h0000_1004, 32'h0000_1004},
        {32'hFFFF_EF73, 32'h0000_0000},
        {32'h0000_000C, 32'h0000_000C}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] idx, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_idx = idx; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx, output logic [31:0] d);
        acc_valid = 1'b1; acc_write = 1'b0; acc_idx = idx;
        #0.5;
        d = acc_rdata;
        acc_valid = 1'b0;
        #0.5;
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        strap_sram_en = strap; rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        logic [31:0] r;
        do_reset(1'b1);
        // R1 / R2 reset state with strap high
        chk("R1 big_endian", {31'b0, big_endian}, 32'd0);
        chk("R1 wbuf_en", {31'b0, wbuf_en}, 32'd0);
        chk("R1 core_clk_en", {31'b0, core_clk_en}, 32'd1);
        chk("R1 pid_out", pid_out, 32'd0);
        chk("R1 pid_wr_pulse", {31'b0, pid_wr_pulse}, 32'd0);
        chk("R2 isram_en strap1", {31'b0, isram_en}, 32'd1);
        chk("R2 dsram_en strap1", {31'b0, dsram_en}, 32'd1);
        rd(4'd1, r); chk("R2 R3 ctrl read after strap1", r, 32'h0000_1004);

        // R3 / R4 vector walk
        for (int i = 0; i < 6; i++) begin
            wr(4'd1, VEC[i][63:32]);
            rd(4'd1, r); chk("R3 ctrl readback", r, VEC[i][31:0]);
            chk("R4 big_endian", {31'b0, big_endian}, {31'b0, VEC[i][7]});
            chk("R3 wbuf_en", {31'b0, wbuf_en}, {31'b0, VEC[i][3]});
            chk("R3 dsram_en", {31'b0, dsram_en}, {31'b0, VEC[i][2]});
            chk("R3 isram_en", {31'b0, isram_en}, {31'b0, VEC[i][12]});
            chk("R8 no pulse on ctrl write", {31'b0, pid_wr_pulse}, 32'd0);
        end

        // R5 wait with late wake
        wr(4'd7, 32'h0);
        chk("R5 enable low after write", {31'b0, core_clk_en}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R5 enable still low", {31'b0, core_clk_en}, 32'd0);
        wake_req = 1'b1;
        @(negedge clk);
        chk("R5 enable back after wake", {31'b0, core_clk_en}, 32'd1);
        wake_req = 1'b0;
        @(negedge clk);
        chk("R5 enable stays high", {31'b0, core_clk_en}, 32'd1);

        // R6 pending wake
        @(negedge clk);
        wake_req = 1'b1;
        wr(4'd7, 32'h0);
        chk("R6 enable low one cycle", {31'b0, core_clk_en}, 32'd0);
        @(negedge clk);
        chk("R6 enable released", {31'b0, core_clk_en}, 32'd1);
        wake_req = 1'b0;

        // R7 / R8 process id
        wr(4'd13, 32'hCAFE_0123);
        chk("R8 pulse after write", {31'b0, pid_wr_pulse}, 32'd1);
        chk("R7 pid_out", pid_out, 32'hCAFE_0123);
        @(negedge clk);
        chk("R8 pulse one cycle", {31'b0, pid_wr_pulse}, 32'd0);
        rd(4'd13, r); chk("R7 pid read", r, 32'hCAFE_0123);

        // R9 ignored accesses
        wr(4'd1, 32'h0000_0088);
        wr(4'd5, 32'hFFFF_FFFF);
        chk("R9 no pulse on other write", {31'b0, pid_wr_pulse}, 32'd0);
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b1; acc_idx = 4'd13; acc_wdata = 32'h1111_1111;
        @(negedge clk);
        acc_idx = 4'd1; acc_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        acc_write = 1'b0;
        chk("R9 no pulse on invalid write", {31'b0, pid_wr_pulse}, 32'd0);
        rd(4'd1, r); chk("R9 ctrl unchanged", r, 32'h0000_0088);
        rd(4'd13, r); chk("R9 pid unchanged", r, 32'hCAFE_0123);
        rd(4'd5, r); chk("R9 other index reads 0", r, 32'd0);
        rd(4'd7, r); chk("R9 core index reads 0", r, 32'd0);
        acc_idx = 4'd13; #0.5;
        chk("R9 read without valid is 0", acc_rdata, 32'd0);

        // R2 / R1 reset with strap low
        do_reset(1'b0);
        chk("R2 isram_en strap0", {31'b0, isram_en}, 32'd0);
        chk("R2 dsram_en strap0", {31'b0, dsram_en}, 32'd0);
        chk("R1 pid cleared", pid_out, 32'd0);
        chk("R1 endian cleared", {31'b0, big_endian}, 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule